// File: doc/BRIEF.md
# SDRAM Bank State and Power-Mode Tracker

This block sits beside a DDR2-style memory controller or device model. On each rising clock edge it samples the command strobes, the bank address, the address bus and the clock-enable line. From these it keeps a record of which of the device's banks hold an open row and which row each one holds. It also tracks the device power state, which is one of normal operation, precharge power-down, active power-down or self refresh.

A sticky violation flag catches protocol misuse. The cases it reports are an access to a closed bank, a second row open on a bank that is already open, and clock enable dropped while a read or write burst is still in flight. Data-path timing, strobes, refresh counting and termination are outside this block.

Top module: `sdr_bank_tracker`

## Requirements
- R1: In normal operation, an edge with `cs_n` high masks the command. No bank flag, no stored row, no power mode and no violation state changes, whatever the values of `ras_n`, `cas_n`, `we_n` and `cke`.
- R2: An activate command ({cs_n,ras_n,cas_n,we_n} = 0011) to a closed bank sets `bank_open[ba]` and stores `addr` as that bank's row. The row appears at `open_row[ba*ROW_W +: ROW_W]` after the edge.
- R3: A precharge command (0010) with `addr[AP_BIT]` low closes only bank `ba`. Every other bank keeps its flag and its row.
- R4: A precharge command with `addr[AP_BIT]` high closes every bank.
- R5: In normal operation, an edge with `cke` low and `cs_n` low, while all banks are idle, moves `pwr_mode` to precharge power-down (1). If the command on that edge is refresh (0001), `pwr_mode` moves to self refresh (3) instead.
- R6: The same entry edge with at least one bank open and a non-refresh command moves `pwr_mode` to active power-down (2).
- R7: From either power-down mode, the first clock edge with `cke` high returns `pwr_mode` to normal operation (0). No command is executed on that edge, and the bank state is kept.
- R8: In self refresh, `pwr_mode` reads 0 as soon as `cke` goes high, with no clock edge needed. It stays at 3 while `cke` is low.
- R9: A read (0101) or write (0100) to an open bank starts a burst window covering the next BURST_CYC edges. An entry edge (`cke` low, `cs_n` low) inside that window sets `violation`. An entry edge after the window does not.
- R10: A read or write to a closed bank, or an activate to an open bank, sets `violation`. An activate to an open bank leaves its stored row unchanged. `violation` stays set until reset.
- R11: Mode register set (0000) and refresh (0001) with `cke` high, and no-operation (0111), change neither the bank state, the power mode nor `violation`.
- R12: An edge with `rst_n` low clears all bank flags and `violation`, and sets `pwr_mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (3) | Bank address |
| addr | input | ROW_W (14) | Row address; bit AP_BIT selects all-bank precharge |
| bank_open | output | NUM_BANKS (8) | One flag per bank, set while a row is open |
| open_row | output | NUM_BANKS*ROW_W (112) | Stored row of each bank, packed by bank index |
| pwr_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest condition to reach is the wake from self refresh with no clock edge, because every other output only moves at an edge. The stimulus first enters self refresh with a refresh command and `cke` low. It then raises `cke` partway through a clock period and reads `pwr_mode` before the next rising edge. The burst-window boundary is also hard to reach. It is approached from both sides: one run drops `cke` exactly on the last edge inside the window, and another drops it on the first edge after the window.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

   typedef enum logic [2:0] {
      C_NOP,
      C_ACT,
      C_RD,
      C_WR,
      C_PRE,
      C_REF,
      C_MRS,
      C_DSEL
   } cmd_e;

   typedef enum logic [1:0] {
      PM_RUN    = 2'd0,
      PM_PRE_PD = 2'd1,
      PM_ACT_PD = 2'd2,
      PM_SREF   = 2'd3
   } pmode_e;

endpackage

// File: rtl/sdr_trk_decode.sv
module sdr_trk_decode
   import sdr_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      case ({cs_n, ras_n, cas_n, we_n})
         4'b0011: cmd = C_ACT;
         4'b0101: cmd = C_RD;
         4'b0100: cmd = C_WR;
         4'b0010: cmd = C_PRE;
         4'b0001: cmd = C_REF;
         4'b0000: cmd = C_MRS;
         default: cmd = cs_n ? C_DSEL : C_NOP;
      endcase
   end

endmodule

// File: rtl/sdr_trk_bank.sv
module sdr_trk_bank #(
   parameter int ROW_W          = 14,
   parameter bit CLEAR_ON_CLOSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_req,
   input  logic             close_req,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)         is_open <= 1'b0;
      else if (open_req)  is_open <= 1'b1;
      else if (close_req) is_open <= 1'b0;
   end

   generate
      if (CLEAR_ON_CLOSE) begin : g_row_clear
         always_ff @(posedge clk) begin
            if (!rst_n)         row_q <= '0;
            else if (open_req)  row_q <= row_in;
            else if (close_req) row_q <= '0;
         end
      end else begin : g_row_hold
         always_ff @(posedge clk) begin
            if (!rst_n)        row_q <= '0;
            else if (open_req) row_q <= row_in;
         end
      end
   endgenerate

   assert_open_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_req |=> (is_open && row_q == $past(row_in)));

   assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (close_req && !open_req) |=> !is_open);

endmodule

// File: rtl/sdr_trk_power.sv
module sdr_trk_power
   import sdr_trk_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cke,
   input  logic   selected,
   input  logic   is_ref,
   input  logic   any_open,
   output pmode_e mode_q,
   output pmode_e pwr_mode
);

   pmode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      case (mode_q)
         PM_RUN: begin
            if (!cke && selected) begin
               if (is_ref)        mode_d = PM_SREF;
               else if (any_open) mode_d = PM_ACT_PD;
               else               mode_d = PM_PRE_PD;
            end
         end
         default: if (cke) mode_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= PM_RUN;
      else        mode_q <= mode_d;
   end

   // Self-refresh wake is visible as soon as cke rises, without a clock edge.
   assign pwr_mode = (mode_q == PM_SREF && cke) ? PM_RUN : mode_q;

   assert_pre_pd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_PRE_PD) |-> !any_open);

   assert_act_pd_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_ACT_PD) |-> any_open);

   assert_pd_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == PM_PRE_PD || mode_q == PM_ACT_PD) && cke) |=> (mode_q == PM_RUN));

   assert_sref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_SREF && !cke) |=> (mode_q == PM_SREF));

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
   import sdr_trk_pkg::*;
#(
   parameter int NUM_BANKS          = 8,
   parameter int ROW_W              = 14,
   parameter int AP_BIT             = 10,
   parameter int BURST_CYC          = 4,
   parameter bit CLEAR_ROW_ON_CLOSE = 1'b1,
   localparam int BA_W              = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] open_row,
   output logic [1:0]                 pwr_mode,
   output logic                       violation
);

   localparam int CNT_W = $clog2(BURST_CYC + 1);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (AP_BIT >= ROW_W) begin : g_bad_ap
         $error("AP_BIT must lie inside the address bus");
      end
      if (BURST_CYC < 1) begin : g_bad_burst
         $error("BURST_CYC must be at least 1");
      end
   endgenerate

   cmd_e             cmd;
   pmode_e           mode_q;
   pmode_e           mode_vis;
   logic             exec;
   logic             tgt_open;
   logic             act_ok;
   logic             rdwr;
   logic             rdwr_ok;
   logic             pre_one;
   logic             pre_all;
   logic             entry_edge;
   logic             viol_evt;
   logic [CNT_W-1:0] burst_q;

   sdr_trk_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   assign exec       = (mode_q == PM_RUN) && cke && (cmd != C_DSEL);
   assign entry_edge = (mode_q == PM_RUN) && !cke && (cmd != C_DSEL);
   assign tgt_open   = bank_open[ba];
   assign act_ok     = exec && (cmd == C_ACT) && !tgt_open;
   assign rdwr       = exec && (cmd == C_RD || cmd == C_WR);
   assign rdwr_ok    = rdwr && tgt_open;
   assign pre_one    = exec && (cmd == C_PRE) && !addr[AP_BIT];
   assign pre_all    = exec && (cmd == C_PRE) && addr[AP_BIT];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic             hit;
         logic [ROW_W-1:0] row_w;
         assign hit = (ba == BA_W'(b));
         sdr_trk_bank #(
            .ROW_W         (ROW_W),
            .CLEAR_ON_CLOSE(CLEAR_ROW_ON_CLOSE)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_req (act_ok && hit),
            .close_req(pre_all || (pre_one && hit)),
            .row_in   (addr),
            .is_open  (bank_open[b]),
            .row_q    (row_w)
         );
         assign open_row[b*ROW_W +: ROW_W] = row_w;
      end
   endgenerate

   sdr_trk_power u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke     (cke),
      .selected(cmd != C_DSEL),
      .is_ref  (cmd == C_REF),
      .any_open(|bank_open),
      .mode_q  (mode_q),
      .pwr_mode(mode_vis)
   );

   assign pwr_mode = mode_vis;

   always_ff @(posedge clk) begin
      if (!rst_n)            burst_q <= '0;
      else if (rdwr_ok)      burst_q <= CNT_W'(BURST_CYC);
      else if (burst_q != 0) burst_q <= burst_q - 1'b1;
   end

   assign viol_evt = (exec && cmd == C_ACT && tgt_open) ||
                     (rdwr && !tgt_open) ||
                     (entry_edge && burst_q != 0);

   always_ff @(posedge clk) begin
      if (!rst_n)        violation <= 1'b0;
      else if (viol_evt) violation <= 1'b1;
   end

   assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && cs_n) |=>
         ($stable(bank_open) && $stable(open_row) && $stable(pwr_mode) && $stable(violation)));

   assert_all_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |=> (bank_open == '0));

   assert_burst_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_edge && burst_q != 0) |=> violation);

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

endmodule

// File: tb/sdr_bank_tracker_tb.sv
module sdr_bank_tracker_tb_top;

   localparam int NB    = 8;
   localparam int RW    = 14;
   localparam int BURST = 4;

   localparam logic [3:0] K_NOP = 4'b0111;
   localparam logic [3:0] K_ACT = 4'b0011;
   localparam logic [3:0] K_RD  = 4'b0101;
   localparam logic [3:0] K_WR  = 4'b0100;
   localparam logic [3:0] K_PRE = 4'b0010;
   localparam logic [3:0] K_REF = 4'b0001;
   localparam logic [3:0] K_MRS = 4'b0000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cke = 1'b1;
   logic             cs_n = 1'b1;
   logic             ras_n = 1'b1;
   logic             cas_n = 1'b1;
   logic             we_n = 1'b1;
   logic [2:0]       ba = '0;
   logic [RW-1:0]    addr = '0;
   logic [NB-1:0]    bank_open;
   logic [NB*RW-1:0] open_row;
   logic [1:0]       pwr_mode;
   logic             violation;

   int n_chk  = 0;
   int n_fail = 0;

   logic [NB-1:0] m_open;
   int            m_row [NB];
   int            m_mode;
   int            m_burst;
   logic          m_viol;

   always #10 clk = ~clk;

   sdr_bank_tracker dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ba       (ba),
      .addr     (addr),
      .bank_open(bank_open),
      .open_row (open_row),
      .pwr_mode (pwr_mode),
      .violation(violation)
   );

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit row_ok = 1'b1;
      int bad = 0;
      for (int b = 0; b < NB; b++)
         if (m_open[b] && int'(open_row[b*RW +: RW]) != m_row[b]) begin
            row_ok = 1'b0;
            bad = b;
         end
      check(bank_open == m_open, tag, "bank_open", int'(bank_open), int'(m_open));
      check(row_ok, tag, "open_row of bank", int'(open_row[bad*RW +: RW]), m_row[bad]);
      check(int'(pwr_mode) == m_mode, tag, "pwr_mode", int'(pwr_mode), m_mode);
      check(violation == m_viol, tag, "violation", int'(violation), int'(m_viol));
   endtask

   task automatic model_reset();
      m_open = '0;
      for (int b = 0; b < NB; b++) m_row[b] = 0;
      m_mode = 0;
      m_burst = 0;
      m_viol = 1'b0;
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      cke = 1'b1;
      {cs_n, ras_n, cas_n, we_n} = K_NOP | 4'b1000;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      compare(tag);
   endtask

   task automatic step(input logic k, input logic [3:0] c, input int b, input int a, input string tag);
      bit ld = 1'b0;
      @(negedge clk);
      cke = k;
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b[2:0];
      addr = a[RW-1:0];
      if (m_mode == 0) begin
         if (!c[3]) begin
            if (k) begin
               case (c)
                  K_ACT: if (m_open[b]) m_viol = 1'b1;
                         else begin m_open[b] = 1'b1; m_row[b] = a; end
                  K_RD, K_WR: if (!m_open[b]) m_viol = 1'b1; else ld = 1'b1;
                  K_PRE: if (a[10]) m_open = '0; else m_open[b] = 1'b0;
                  default: ;
               endcase
            end else begin
               if (m_burst > 0) m_viol = 1'b1;
               m_mode = (c == K_REF) ? 3 : ((|m_open) ? 2 : 1);
            end
         end
      end else if (k) begin
         m_mode = 0;
      end
      m_burst = ld ? BURST : ((m_burst > 0) ? m_burst - 1 : 0);
      @(posedge clk);
      #5;
      compare(tag);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (2) @(negedge clk);
      do_reset("R12");

      // R2: open every bank with its own row
      for (int b = 0; b < NB; b++) step(1, K_ACT, b, 100 + b * 37, "R2");

      // R1: every strobe pattern with chip select high, cke high and low
      for (int k = 0; k < 2; k++)
         for (int c = 0; c < 8; c++)
            step(k[0], 4'b1000 | 4'(c), c, 1024 + c, "R1");

      // R3: single-bank precharge, each bank in turn, then reopen
      for (int b = 0; b < NB; b++) begin
         step(1, K_PRE, b, 0, "R3");
         step(1, K_ACT, b, 3000 + b, "R2");
      end

      // R11: mode register set, refresh, no-op leave state alone
      step(1, K_MRS, 1, 16'h0155, "R11");
      step(1, K_MRS, 2, 16'h0200, "R11");
      step(1, K_REF, 0, 0, "R11");
      step(1, K_NOP, 3, 0, "R11");

      // R4: all-bank precharge
      step(1, K_PRE, 5, 1 << 10, "R4");

      // R6, R7: active power-down with one open bank
      step(1, K_ACT, 1, 777, "R2");
      step(0, K_NOP, 0, 0, "R6");
      step(0, K_NOP, 0, 0, "R6");
      step(0, K_ACT, 2, 5, "R6");
      step(1, K_ACT, 3, 9, "R7");
      step(1, K_NOP, 0, 0, "R7");

      // R5: precharge power-down, then exit
      step(1, K_PRE, 0, 1 << 10, "R4");
      step(0, K_NOP, 0, 0, "R5");
      step(0, K_NOP, 0, 0, "R5");
      step(1, K_NOP, 0, 0, "R7");

      // R5, R8: self refresh entry and clock-free wake
      step(0, K_REF, 0, 0, "R5");
      step(0, K_NOP, 0, 0, "R8");
      #2;
      check(pwr_mode == 2'd3, "R8", "pwr_mode before wake", int'(pwr_mode), 3);
      cke = 1'b1;
      #1;
      check(pwr_mode == 2'd0, "R8", "pwr_mode after cke rise", int'(pwr_mode), 0);
      step(1, K_NOP, 0, 0, "R8");

      // R9: drop cke on the first edge after the burst window
      step(1, K_ACT, 4, 44, "R2");
      step(1, K_RD, 4, 0, "R9");
      for (int i = 0; i < BURST; i++) step(1, K_NOP, 0, 0, "R9");
      step(0, K_NOP, 0, 0, "R9");
      step(1, K_NOP, 0, 0, "R7");

      // R9: drop cke on the last edge inside the burst window
      step(1, K_WR, 4, 0, "R9");
      for (int i = 0; i < BURST - 1; i++) step(1, K_NOP, 0, 0, "R9");
      step(0, K_NOP, 0, 0, "R9");
      step(1, K_NOP, 0, 0, "R9");

      // R10: access to closed bank
      do_reset("R12");
      step(1, K_RD, 6, 0, "R10");
      step(1, K_NOP, 0, 0, "R10");
      do_reset("R12");
      step(1, K_WR, 2, 0, "R10");

      // R10: double activate keeps the row and the flag stays set
      do_reset("R12");
      step(1, K_ACT, 0, 321, "R2");
      step(1, K_ACT, 0, 999, "R10");
      step(1, K_PRE, 0, 1 << 10, "R10");
      step(1, K_NOP, 0, 0, "R10");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule